// File: doc/BRIEF.md
# Indirect Register Access Port

This block is the host side of a peripheral whose internal configuration registers are not mapped one by one onto the processor bus. A CPU sees only two byte-wide locations. It writes a register number to the first location. It then moves data through the second location, one byte per access. Registers wider than a byte are stepped through low byte first, and a byte pointer advances on each data access. The same first location, when read, hands back the set of interrupt sources that have fired since the last such read, and clears that set in the same access.

Interrupt sources arrive as single-cycle pulses on an eight-bit input and are latched until the CPU collects them. An interrupt line stays raised while anything is latched, unless the mask bit of the init register is set. Register contents are driven out as plain configuration outputs for the function units that sit behind the port. Those units are not part of this block.

Top module: `ireg_port`

## Requirements
- R1: A write with `bus_addr`=0 stores `bus_wdata` as the selected register number. Later accesses with `bus_addr`=1 reach that register. Implemented numbers are 0x21 (init), 0x69 (mode one), 0x6A (mode two), 0x63 (gain A) and 0x64 (gain B). All of them reset to zero.
- R2: Gain A and gain B are 16 bits wide. The first data write after selection fills bits 7:0 and the second fills bits 15:8. Data reads return the bytes in the same order.
- R3: Every command write returns the byte pointer to the low byte, even when the same register is selected again.
- R4: A data write past a register's last byte changes nothing. A data read past the last byte returns 0x00.
- R5: Init, mode one and mode two are 8 bits wide and take exactly one data byte.
- R6: A read with `bus_addr`=0 returns the pending bitmask. Bit i is set when `irq_src[i]` has pulsed since the previous such read. The read clears the mask. `bus_rdata` holds the value from the clock edge that ends the read strobe.
- R7: A source pulse in the same cycle as the clearing read is not lost. It shows up in the next status read.
- R8: `irq_o` is 1 exactly when the pending mask is nonzero and bit 2 (value 0x04) of the init register is 0.
- R9: A data access to an unimplemented register number reads 0x00 and leaves every implemented register unchanged.
- R10: `law_alaw` follows bit 0 of mode one: 1 selects A-law and 0 selects mu-law.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 1 | 0 selects command/status, 1 selects data |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_src | input | 8 | Interrupt source pulses |
| irq_o | output | 1 | Interrupt request |
| cfg_init | output | 8 | Init register |
| cfg_mode1 | output | 8 | Mode register one |
| cfg_mode2 | output | 8 | Mode register two |
| cfg_gain_a | output | 16 | Gain register A |
| cfg_gain_b | output | 16 | Gain register B |
| law_alaw | output | 1 | Companding law select |

## Verification
The bench builds the block with its default parameters: eight interrupt sources, byte-wide data and a two-byte maximum register width. With those defaults the pointer reaches its overrun position after only two accesses, and each interrupt bit maps to one pin of the source bus. The directed cases interleave partial writes with reselection. They also place a source pulse on the exact cycle of a status read, and toggle the mask bit while interrupts are pending, so the boundary between cleared and retained status is observed at the ports.

// File: rtl/ireg_pkg.sv
package ireg_pkg;
    localparam int BYTE_W    = 8;
    localparam int SEL_W     = 8;
    localparam int REG_N     = 5;
    localparam int MAX_BYTES = 2;
    localparam int WORD_W    = BYTE_W * MAX_BYTES;
    localparam int PTR_W     = $clog2(MAX_BYTES + 1);
    localparam int IDX_W     = $clog2(REG_N);

    localparam int IDX_INIT  = 0;
    localparam int IDX_MODE1 = 1;
    localparam int IDX_MODE2 = 2;
    localparam int IDX_GAINA = 3;
    localparam int IDX_GAINB = 4;

    localparam int INIT_MASK_BIT = 2;

    function automatic logic [SEL_W-1:0] reg_num(input int i);
        case (i)
            IDX_INIT:  return 8'h21;
            IDX_MODE1: return 8'h69;
            IDX_MODE2: return 8'h6A;
            IDX_GAINA: return 8'h63;
            default:   return 8'h64;
        endcase
    endfunction

    function automatic logic [PTR_W-1:0] reg_len(input int i);
        return (i >= IDX_GAINA) ? PTR_W'(2) : PTR_W'(1);
    endfunction
endpackage

// File: rtl/ireg_seq.sv
module ireg_seq
    import ireg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic             data_acc,
    input  logic [BYTE_W-1:0] wdata,
    output logic [IDX_W-1:0] hit_idx,
    output logic [PTR_W-1:0] ptr_q,
    output logic             in_range
);
    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [PTR_W-1:0] ptr;
    } seq_t;

    seq_t s_d, s_q;
    logic             hit;
    logic [PTR_W-1:0] hit_len;

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        hit_len = '0;
        for (int i = 0; i < REG_N; i++) begin
            if (s_q.sel == reg_num(i)) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
                hit_len = reg_len(i);
            end
        end
        in_range = hit && (s_q.ptr < hit_len);

        s_d = s_q;
        if (cmd_wr) begin
            s_d.sel = wdata;
            s_d.ptr = '0;
        end else if (data_acc && in_range) begin
            s_d.ptr = s_q.ptr + PTR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ptr_q = s_q.ptr;

    assert_cmd_resets_ptr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> (s_q.ptr == '0 && s_q.sel == $past(wdata)));

    assert_ptr_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (s_q.ptr <= hit_len));
endmodule

// File: rtl/ireg_file.sv
module ireg_file
    import ireg_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             idx,
    input  logic [PTR_W-1:0]             ptr,
    input  logic [BYTE_W-1:0]            wdata,
    output logic [REG_N-1:0][WORD_W-1:0] regs_q
);
    typedef struct packed {
        logic [REG_N-1:0][WORD_W-1:0] word;
    } file_t;

    file_t f_d, f_q;
    logic [REG_N-1:0] we_vec;

    for (genvar g = 0; g < REG_N; g++) begin : g_we
        assign we_vec[g] = wr_en && (idx == IDX_W'(g));
    end

    always_comb begin
        f_d = f_q;
        for (int i = 0; i < REG_N; i++) begin
            for (int b = 0; b < MAX_BYTES; b++) begin
                if (we_vec[i] && ptr == PTR_W'(b))
                    f_d.word[i][b*BYTE_W +: BYTE_W] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign regs_q = f_q.word;

    assert_single_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we_vec));

    assert_hold_without_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(f_q));
endmodule

// File: rtl/ireg_intr.sv
module ireg_intr #(
    parameter int IRQ_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_W-1:0] src,
    input  logic             clr,
    input  logic             mask,
    output logic [IRQ_W-1:0] pend_q,
    output logic             irq
);
    typedef struct packed {
        logic [IRQ_W-1:0] pend;
    } intr_t;

    intr_t i_d, i_q;

    always_comb begin
        i_d = i_q;
        if (clr) i_d.pend = src;
        else     i_d.pend = i_q.pend | src;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) i_q <= '0;
        else        i_q <= i_d;
    end

    assign pend_q = i_q.pend;
    assign irq    = (|i_q.pend) && !mask;

    assert_src_latched_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (src != '0) |=> ((i_q.pend & $past(src)) == $past(src)));

    assert_clear_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && src == '0) |=> (i_q.pend == '0));
endmodule

// File: rtl/ireg_port.sv
module ireg_port
    import ireg_pkg::*;
#(
    parameter int IRQ_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic [IRQ_W-1:0] irq_src,
    output logic             irq_o,
    output logic [7:0]       cfg_init,
    output logic [7:0]       cfg_mode1,
    output logic [7:0]       cfg_mode2,
    output logic [15:0]      cfg_gain_a,
    output logic [15:0]      cfg_gain_b,
    output logic             law_alaw
);
    typedef struct packed {
        logic [BYTE_W-1:0] rdata;
    } port_t;

    port_t p_d, p_q;

    logic cmd_wr, status_rd, data_wr, data_acc;
    logic [IDX_W-1:0] hit_idx;
    logic [PTR_W-1:0] ptr;
    logic in_range;
    logic [REG_N-1:0][WORD_W-1:0] regs;
    logic [IRQ_W-1:0] pend;
    logic [BYTE_W-1:0] data_byte;

    // Write wins when both strobes are raised together.
    assign cmd_wr    = bus_wr && !bus_addr;
    assign data_wr   = bus_wr && bus_addr;
    assign status_rd = bus_rd && !bus_wr && !bus_addr;
    assign data_acc  = bus_addr && (bus_wr || bus_rd);

    ireg_seq u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .data_acc(data_acc),
        .wdata(bus_wdata), .hit_idx(hit_idx), .ptr_q(ptr), .in_range(in_range)
    );

    ireg_file u_file (
        .clk(clk), .rst_n(rst_n), .wr_en(data_wr && in_range), .idx(hit_idx),
        .ptr(ptr), .wdata(bus_wdata), .regs_q(regs)
    );

    ireg_intr #(.IRQ_W(IRQ_W)) u_intr (
        .clk(clk), .rst_n(rst_n), .src(irq_src), .clr(status_rd),
        .mask(regs[IDX_INIT][INIT_MASK_BIT]), .pend_q(pend), .irq(irq_o)
    );

    always_comb begin
        data_byte = '0;
        for (int b = 0; b < MAX_BYTES; b++) begin
            if (in_range && ptr == PTR_W'(b))
                data_byte = regs[hit_idx][b*BYTE_W +: BYTE_W];
        end
        p_d = p_q;
        if (status_rd)
            p_d.rdata = BYTE_W'(pend);
        else if (bus_rd && !bus_wr && bus_addr)
            p_d.rdata = data_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign bus_rdata  = p_q.rdata;
    assign cfg_init   = regs[IDX_INIT][7:0];
    assign cfg_mode1  = regs[IDX_MODE1][7:0];
    assign cfg_mode2  = regs[IDX_MODE2][7:0];
    assign cfg_gain_a = regs[IDX_GAINA];
    assign cfg_gain_b = regs[IDX_GAINB];
    assign law_alaw   = cfg_mode1[0];

    assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_init[INIT_MASK_BIT] |-> !irq_o);

    assert_irq_needs_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend != '0));

    assert_status_read_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        status_rd |=> (bus_rdata == BYTE_W'($past(pend))));
endmodule

// File: tb/ireg_port_test.sv
module ireg_port_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0, irq_src = '0;
    logic [7:0] bus_rdata, cfg_init, cfg_mode1, cfg_mode2;
    logic [15:0] cfg_gain_a, cfg_gain_b;
    logic irq_o, law_alaw;
    int n_checks = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ireg_port uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_src(irq_src), .irq_o(irq_o), .cfg_init(cfg_init),
        .cfg_mode1(cfg_mode1), .cfg_mode2(cfg_mode2), .cfg_gain_a(cfg_gain_a),
        .cfg_gain_b(cfg_gain_b), .law_alaw(law_alaw)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    endtask

    task automatic pulse(input logic [7:0] s);
        @(negedge clk); irq_src = s;
        @(negedge clk); irq_src = '0;
    endtask

    task automatic t_reset;
        check(cfg_init == 0 && cfg_mode1 == 0 && cfg_mode2 == 0, "R1 reset cfg", cfg_init, 0);
        check(cfg_gain_a == 0 && cfg_gain_b == 0, "R1 reset gains", cfg_gain_a, 0);
        check(irq_o == 0 && bus_rdata == 0, "R8 reset irq", irq_o, 0);
    endtask

    task automatic t_sixteen;
        logic [7:0] v;
        wr(0, 8'h63); wr(1, 8'h34); wr(1, 8'h12);
        check(cfg_gain_a == 16'h1234, "R2 gain A low then high", cfg_gain_a, 16'h1234);
        wr(0, 8'h64); wr(1, 8'hCD); wr(1, 8'hAB);
        check(cfg_gain_b == 16'hABCD, "R2 gain B", cfg_gain_b, 16'hABCD);
        wr(0, 8'h63); rd(1, v);
        check(v == 8'h34, "R2 read low byte", v, 8'h34);
        rd(1, v);
        check(v == 8'h12, "R2 read high byte", v, 8'h12);
        rd(1, v);
        check(v == 8'h00, "R4 read past end", v, 0);
        wr(1, 8'h77);
        check(cfg_gain_a == 16'h1234, "R4 write past end ignored", cfg_gain_a, 16'h1234);
    endtask

    task automatic t_reselect;
        wr(0, 8'h64); wr(1, 8'hEE);
        check(cfg_gain_b == 16'hABEE, "R3 partial write low byte", cfg_gain_b, 16'hABEE);
        wr(0, 8'h64); wr(1, 8'h11); wr(1, 8'h22);
        check(cfg_gain_b == 16'h2211, "R3 reselect restarts at low byte", cfg_gain_b, 16'h2211);
    endtask

    task automatic t_eight;
        logic [7:0] v;
        wr(0, 8'h6A); wr(1, 8'h5A); wr(1, 8'hFF);
        check(cfg_mode2 == 8'h5A, "R5 mode two single byte", cfg_mode2, 8'h5A);
        wr(0, 8'h69); wr(1, 8'h01);
        check(law_alaw == 1'b1 && cfg_mode1 == 8'h01, "R10 A-law select", law_alaw, 1);
        wr(0, 8'h69); wr(1, 8'h00);
        check(law_alaw == 1'b0, "R10 mu-law select", law_alaw, 0);
        wr(0, 8'h6A); rd(1, v);
        check(v == 8'h5A, "R1 read mode two", v, 8'h5A);
        rd(1, v);
        check(v == 8'h00, "R5 second read past end", v, 0);
    endtask

    task automatic t_unimpl;
        logic [7:0] v;
        wr(0, 8'h65); wr(1, 8'h99); wr(1, 8'h88); rd(1, v);
        check(v == 8'h00, "R9 unimplemented reads zero", v, 0);
        check(cfg_gain_a == 16'h1234 && cfg_gain_b == 16'h2211 && cfg_mode2 == 8'h5A
              && cfg_init == 8'h00, "R9 no register touched", cfg_gain_b, 16'h2211);
    endtask

    task automatic t_irq;
        logic [7:0] v;
        pulse(8'h02); pulse(8'h80);
        check(irq_o == 1'b1, "R8 irq raised", irq_o, 1);
        // Status read with a new source on the same cycle.
        @(negedge clk); bus_addr = 0; bus_rd = 1; irq_src = 8'h10;
        @(negedge clk); bus_rd = 0; irq_src = 0; v = bus_rdata;
        check(v == 8'h82, "R6 pending bitmask", v, 8'h82);
        check(irq_o == 1'b1, "R7 same-cycle source keeps irq", irq_o, 1);
        rd(0, v);
        check(v == 8'h10, "R7 same-cycle source kept", v, 8'h10);
        check(irq_o == 1'b0, "R6 cleared by read", irq_o, 0);
        rd(0, v);
        check(v == 8'h00, "R6 second read empty", v, 0);
    endtask

    task automatic t_mask;
        logic [7:0] v;
        wr(0, 8'h21); wr(1, 8'h05);
        pulse(8'h01);
        check(cfg_init == 8'h05 && irq_o == 1'b0, "R8 masked", irq_o, 0);
        wr(0, 8'h21); wr(1, 8'h01);
        check(irq_o == 1'b1, "R8 unmasked pending", irq_o, 1);
        rd(0, v);
        check(v == 8'h01 && irq_o == 1'b0, "R6 masked source still latched", v, 1);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sixteen();
        t_reselect();
        t_eight();
        t_unimpl();
        t_irq();
        t_mask();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule